// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register file of a serial port. Software reaches it over a 32-bit bus that selects a word by its byte address. Behind the bus are the port's control, status, FIFO-control, baud and one-millisecond registers. The block also holds a one-character receive buffer and emits a one-cycle transmit strobe. The baud generator, the FIFOs and the serializer live outside the block. The transmitter is treated as finishing at once, so the transmit-ready and transmit-done flags never fall.

A byte-wide receive interface delivers characters or break events into the holding buffer. A read of the receive data word takes the character out of the buffer. A single registered interrupt line combines status bits with enable bits, most of which share a bit position with the status bit they enable.

Top module: `uart_regfile`

## Requirements
- R1: After reset the registers read as follows. control1 = 0x0000, control2 = 0x0001, control3 = 0x0700, control4 = 0x0000. FIFO control, modulator and one-ms read 0x0000, and baud count reads 0x0004. status1 = 0x6040 (bit 13 transmit-ready, bit 6 receiver-idle, bit 14 RTS-status). status2 = 0x4028 (bit 14 transmit-FIFO-empty, bit 3 transmit-done, bit 5 carrier-detect-input). The test register = 0x0060 (bit 5 rx-empty, bit 6 tx-empty). Receive data = 0x4000 (bit 14 error).
- R2: The word index is the byte address shifted right by two. A read of any index not named in these requirements returns 0, and so does a read of transmit data (0x10). A write to such an index changes no register.
- R3: Writes to control1 (0x20), control3 (0x22), control4 (0x23), FIFO control (0x24), modulator (0x2A) and one-ms (0x2C) keep bits 15:0, and the register reads back that value. A write to baud increment (0x29) lands in baud count (0x2B), and baud increment always reads 0. Writes to baud count are ignored.
- R4: A write to control2 (0x21) with bit 0 clear resets every register and the receive buffer to their R1 values. In every case control2 then stores the low 16 data bits with bit 0 forced to 1.
- R5: While status1 bit 9 (receive-ready) is clear, rx_ready_o is high. A character accepted on rx_valid_i sets status1 bit 9 and status2 bit 0 (data-ready), clears test bit 5, and stores the zero-extended byte in the buffer.
- R6: While a character is held, rx_ready_o is low, and rx_valid_i or rx_break_i neither changes the buffer nor sets any flag.
- R7: An accepted rx_break_i stores 0x5800 (bit 11 break, bit 12 frame error, bit 14 error) and sets status2 bit 2 (break-detect), along with the R5 flags.
- R8: A read of receive data (0x00) while a character is held returns the buffer ORed with bit 15 (character-ready). It also clears status1 bit 9 and status2 bit 0, and sets test bit 5. While the buffer is empty the read returns the buffer without bit 15 and changes nothing.
- R9: A write to transmit data (0x10) with control2 bit 2 set raises tx_strobe_o for the next cycle, with tx_data_o equal to data bits 7:0. With bit 2 clear there is no strobe. Status1 bit 13 and status2 bit 3 stay set either way.
- R10: A write to status1 clears the bits that are 1 in both the data and mask 0x8DB8. A write to status2 does the same with mask 0x1086 (overrun bit 1, break-detect bit 2, wake bit 7, idle bit 12). Writes to the test register (0x2D) are ignored.
- R11: The interrupt is requested when status1 AND control1 has bit 9 or bit 13 set (receive-ready enable bit 9, transmit-ready enable bit 13).
- R12: The interrupt is also requested when status2 AND a mask is nonzero. The mask holds bit 14 when control1 bit 6 is set, plus control4 bits 3 (transmit-complete enable) and 0 (receive-data enable).
- R13: irq_o is registered. It takes the value of the R11/R12 request one cycle after the state that produces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| rx_valid_i | input | 1 | Received character present |
| rx_break_i | input | 1 | Break condition present |
| rx_data_i | input | 8 | Received character |
| rx_ready_o | output | 1 | Buffer can accept a character |
| tx_strobe_o | output | 1 | One-cycle transmit pulse |
| tx_data_o | output | 8 | Character being transmitted |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a full buffer meeting new receive traffic while other events happen around it. Examples are a break arriving while a character is held, a status2 clear landing next to a break, or a software reset while the buffer is full. The random phase mixes receive pushes, breaks, data reads, status clears and occasional software resets in every order. A bench model tracks the buffer's occupancy, and every read and every interrupt level is compared against that model, one cycle after each operation.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int REG_W = 16;

  localparam int IDX_RXD  = 'h00;
  localparam int IDX_TXD  = 'h10;
  localparam int IDX_CTL1 = 'h20;
  localparam int IDX_CTL2 = 'h21;
  localparam int IDX_CTL3 = 'h22;
  localparam int IDX_CTL4 = 'h23;
  localparam int IDX_FIFO = 'h24;
  localparam int IDX_STS1 = 'h25;
  localparam int IDX_STS2 = 'h26;
  localparam int IDX_BINC = 'h29;
  localparam int IDX_BMOD = 'h2A;
  localparam int IDX_BCNT = 'h2B;
  localparam int IDX_MSEC = 'h2C;
  localparam int IDX_TEST = 'h2D;

  localparam int CTL1_TXMT_EN = 6;
  localparam int CTL2_SRST    = 0;
  localparam int CTL2_TXEN    = 2;
  localparam int STS1_RRDY    = 9;
  localparam int STS2_RDR     = 0;
  localparam int STS2_BRK     = 2;
  localparam int TEST_RXMT    = 5;
  localparam int TEST_TXMT    = 6;
  localparam int RXD_CHRDY    = 15;

  localparam logic [REG_W-1:0] RST_CTL2  = 16'h0001;
  localparam logic [REG_W-1:0] RST_CTL3  = 16'h0700;
  localparam logic [REG_W-1:0] RST_BCNT  = 16'h0004;
  localparam logic [REG_W-1:0] RST_STS1  = 16'h6040;
  localparam logic [REG_W-1:0] RST_STS2  = 16'h4028;
  localparam logic [REG_W-1:0] RST_RXBUF = 16'h4000;
  localparam logic [REG_W-1:0] BRK_WORD  = 16'h5800;

  localparam logic [REG_W-1:0] W1C_STS1  = 16'h8DB8;
  localparam logic [REG_W-1:0] W1C_STS2  = 16'h1086;
  localparam logic [REG_W-1:0] RDY_MASK  = 16'h2200;
  localparam logic [REG_W-1:0] TXFE_MASK = 16'h4000;
  localparam logic [REG_W-1:0] CTL4_MASK = 16'h0009;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rf_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             push_i,
  input  logic             brk_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic             pop_i,
  output logic             full_o,
  output logic [REG_W-1:0] buf_o,
  output logic             brk_set_o
);
  logic             full_q;
  logic [REG_W-1:0] buf_q;
  logic             accept;

  assign accept    = (push_i | brk_i) & ~full_q & ~srst_i;
  assign brk_set_o = accept & brk_i;
  assign full_o    = full_q;
  assign buf_o     = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= RST_RXBUF;
    end else if (srst_i) begin
      full_q <= 1'b0;
      buf_q  <= RST_RXBUF;
    end else begin
      if (pop_i) full_q <= 1'b0;
      if (accept) begin
        full_q <= 1'b1;
        buf_q  <= brk_i ? BRK_WORD : REG_W'(data_i);
      end
    end
  end

  p_hold_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !pop_i && !srst_i) |=> (full_q && $stable(buf_q)));

  p_pop_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && full_q) |=> !full_q);
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_rf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] sts1_i,
  input  logic [REG_W-1:0] ctl1_i,
  input  logic [REG_W-1:0] sts2_i,
  input  logic [REG_W-1:0] ctl4_i,
  output logic             irq_o
);
  logic             term1, term2;
  logic [REG_W-1:0] mask2;
  logic             irq_q;

  // enable bits share positions with the status bits they qualify
  assign term1 = |(sts1_i & ctl1_i & RDY_MASK);
  assign mask2 = (ctl1_i[CTL1_TXMT_EN] ? TXFE_MASK : '0) | (ctl4_i & CTL4_MASK);
  assign term2 = |(sts2_i & mask2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= term1 | term2;
  end

  assign irq_o = irq_q;

  p_irq_term1_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term1 |=> irq_o);

  p_irq_term2_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term2 |=> irq_o);

  p_irq_drop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!term1 && !term2) |=> !irq_o);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_valid_i,
  input  logic              rx_break_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_strobe_o,
  output logic [CHAR_W-1:0] tx_data_o,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] wd;
  logic             wr, rd, srst;

  logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q, fifo_q, bmod_q, bcnt_q, msec_q;
  logic [REG_W-1:0] sts1_q, sts2_q;
  logic [REG_W-1:0] sts1_rd, sts2_rd, test_rd, rxd_rd;
  logic             tx_stb_q;
  logic [CHAR_W-1:0] tx_dat_q;

  logic             rx_full, brk_set, pop;
  logic [REG_W-1:0] rx_buf;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[DATA_W-1:REG_W], addr_i[1:0]};

  assign idx  = addr_i[ADDR_W-1:2];
  assign wd   = wdata_i[REG_W-1:0];
  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;
  assign srst = wr && (idx == IDX_W'(IDX_CTL2)) && !wd[CTL2_SRST];
  assign pop  = rd && (idx == IDX_W'(IDX_RXD)) && rx_full;

  uart_rx_hold #(.CHAR_W(CHAR_W)) rx_hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .push_i    (rx_valid_i),
    .brk_i     (rx_break_i),
    .data_i    (rx_data_i),
    .pop_i     (pop),
    .full_o    (rx_full),
    .buf_o     (rx_buf),
    .brk_set_o (brk_set)
  );

  // receive-ready, data-ready and rx-empty all track buffer occupancy
  always_comb begin
    sts1_rd = sts1_q;
    sts1_rd[STS1_RRDY] = rx_full;
    sts2_rd = sts2_q;
    sts2_rd[STS2_RDR] = rx_full;
    test_rd = '0;
    test_rd[TEST_RXMT] = ~rx_full;
    test_rd[TEST_TXMT] = 1'b1;
    rxd_rd = rx_buf;
    rxd_rd[RXD_CHRDY] = rx_buf[RXD_CHRDY] | rx_full;
  end

  assign rx_ready_o = ~rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q <= '0; ctl2_q <= RST_CTL2; ctl3_q <= RST_CTL3; ctl4_q <= '0;
      fifo_q <= '0; bmod_q <= '0; bcnt_q <= RST_BCNT; msec_q <= '0;
      sts1_q <= RST_STS1; sts2_q <= RST_STS2;
      tx_stb_q <= 1'b0; tx_dat_q <= '0;
    end else begin
      tx_stb_q <= 1'b0;
      if (srst) begin
        ctl1_q <= '0; ctl3_q <= RST_CTL3; ctl4_q <= '0;
        fifo_q <= '0; bmod_q <= '0; bcnt_q <= RST_BCNT; msec_q <= '0;
        sts1_q <= RST_STS1; sts2_q <= RST_STS2;
        ctl2_q <= wd | RST_CTL2;
      end else begin
        if (wr) begin
          case (idx)
            IDX_W'(IDX_CTL1): ctl1_q <= wd;
            IDX_W'(IDX_CTL2): ctl2_q <= wd;
            IDX_W'(IDX_CTL3): ctl3_q <= wd;
            IDX_W'(IDX_CTL4): ctl4_q <= wd;
            IDX_W'(IDX_FIFO): fifo_q <= wd;
            IDX_W'(IDX_STS1): sts1_q <= sts1_q & ~(wd & W1C_STS1);
            IDX_W'(IDX_STS2): sts2_q <= sts2_q & ~(wd & W1C_STS2);
            IDX_W'(IDX_BINC): bcnt_q <= wd;
            IDX_W'(IDX_BMOD): bmod_q <= wd;
            IDX_W'(IDX_MSEC): msec_q <= wd;
            IDX_W'(IDX_TXD): begin
              if (ctl2_q[CTL2_TXEN]) begin
                tx_stb_q <= 1'b1;
                tx_dat_q <= wd[CHAR_W-1:0];
              end
            end
            default: ;
          endcase
        end
        if (brk_set) sts2_q[STS2_BRK] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx)
      IDX_W'(IDX_RXD):  rdata_o = DATA_W'(rxd_rd);
      IDX_W'(IDX_CTL1): rdata_o = DATA_W'(ctl1_q);
      IDX_W'(IDX_CTL2): rdata_o = DATA_W'(ctl2_q);
      IDX_W'(IDX_CTL3): rdata_o = DATA_W'(ctl3_q);
      IDX_W'(IDX_CTL4): rdata_o = DATA_W'(ctl4_q);
      IDX_W'(IDX_FIFO): rdata_o = DATA_W'(fifo_q);
      IDX_W'(IDX_STS1): rdata_o = DATA_W'(sts1_rd);
      IDX_W'(IDX_STS2): rdata_o = DATA_W'(sts2_rd);
      IDX_W'(IDX_BMOD): rdata_o = DATA_W'(bmod_q);
      IDX_W'(IDX_BCNT): rdata_o = DATA_W'(bcnt_q);
      IDX_W'(IDX_MSEC): rdata_o = DATA_W'(msec_q);
      IDX_W'(IDX_TEST): rdata_o = DATA_W'(test_rd);
      default:          rdata_o = '0;
    endcase
  end

  assign tx_strobe_o = tx_stb_q;
  assign tx_data_o   = tx_dat_q;

  uart_irq_gen irq_gen_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sts1_i (sts1_rd),
    .ctl1_i (ctl1_q),
    .sts2_i (sts2_rd),
    .ctl4_i (ctl4_q),
    .irq_o  (irq_o)
  );

  p_srst_bit_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl2_q[CTL2_SRST]);

  p_tx_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strobe_o |-> $past(ctl2_q[CTL2_TXEN]));

  p_tx_flags_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts1_rd[13] && sts2_rd[3]));

  p_test_write_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == IDX_W'(IDX_TEST)) |=> $stable(ctl1_q) && $stable(sts2_q[14:3]));
endmodule

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_strobe, irq;
  logic [7:0]  tx_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_break_i(rx_break),
    .rx_data_i(rx_data), .rx_ready_o(rx_ready), .tx_strobe_o(tx_strobe),
    .tx_data_o(tx_data), .irq_o(irq)
  );

  logic [15:0] m_c1, m_c2, m_c3, m_c4, m_fifo, m_mod, m_cnt, m_ms, m_s1, m_s2, m_buf;
  bit m_full;

  function automatic void m_reset();
    m_c1 = 0; m_c2 = 16'h1; m_c3 = 16'h0700; m_c4 = 0; m_fifo = 0; m_mod = 0;
    m_cnt = 16'h4; m_ms = 0; m_s1 = 16'h6040; m_s2 = 16'h4028; m_buf = 16'h4000;
    m_full = 0;
  endfunction

  function automatic logic [31:0] exp_rd(int idx);
    case (idx)
      'h00: return {16'h0, m_buf | (m_full ? 16'h8000 : 16'h0)};
      'h20: return {16'h0, m_c1};
      'h21: return {16'h0, m_c2};
      'h22: return {16'h0, m_c3};
      'h23: return {16'h0, m_c4};
      'h24: return {16'h0, m_fifo};
      'h25: return {16'h0, m_s1 | (m_full ? 16'h0200 : 16'h0)};
      'h26: return {16'h0, m_s2 | (m_full ? 16'h0001 : 16'h0)};
      'h2A: return {16'h0, m_mod};
      'h2B: return {16'h0, m_cnt};
      'h2C: return {16'h0, m_ms};
      'h2D: return m_full ? 32'h40 : 32'h60;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_irq();
    logic [15:0] s1, s2, mk;
    s1 = m_s1 | (m_full ? 16'h0200 : 16'h0);
    s2 = m_s2 | (m_full ? 16'h0001 : 16'h0);
    mk = (m_c1[6] ? 16'h4000 : 16'h0) | (m_c4 & 16'h0009);
    return ((s1 & m_c1 & 16'h2200) != 0) || ((s2 & mk) != 0);
  endfunction

  function automatic void m_write(int idx, logic [31:0] d);
    case (idx)
      'h20: m_c1 = d[15:0];
      'h21: begin if (!d[0]) m_reset(); m_c2 = d[15:0] | 16'h1; end
      'h22: m_c3 = d[15:0];
      'h23: m_c4 = d[15:0];
      'h24: m_fifo = d[15:0];
      'h25: m_s1 = m_s1 & ~(d[15:0] & 16'h8DB8);
      'h26: m_s2 = m_s2 & ~(d[15:0] & 16'h1086);
      'h29: m_cnt = d[15:0];
      'h2A: m_mod = d[15:0];
      'h2C: m_ms = d[15:0];
      default: ;
    endcase
  endfunction

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(int idx, logic [31:0] d);
    bit txen;
    txen = m_c2[2];
    @(negedge clk);
    req = 1; we = 1; addr = 12'(idx << 2); wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    m_write(idx, d);
    if (idx == 'h10) begin
      chk("R9 tx strobe", {31'h0, tx_strobe}, {31'h0, txen});
      if (txen) chk("R9 tx data", {24'h0, tx_data}, {24'h0, d[7:0]});
    end else
      chk("R9 no strobe", {31'h0, tx_strobe}, 32'h0);
  endtask

  task automatic bus_rd(int idx, string req_tag);
    logic [31:0] e;
    e = exp_rd(idx);
    @(negedge clk);
    req = 1; we = 0; addr = 12'(idx << 2);
    #1 chk(req_tag, rdata, e);
    @(negedge clk);
    req = 0;
    if (idx == 0 && m_full) m_full = 0;
  endtask

  task automatic rx_push(logic [7:0] d, bit brk);
    @(negedge clk);
    chk("R6 rx_ready", {31'h0, rx_ready}, {31'h0, !m_full});
    rx_valid = !brk; rx_break = brk; rx_data = d;
    @(negedge clk);
    rx_valid = 0; rx_break = 0;
    if (!m_full) begin
      m_full = 1;
      m_buf = brk ? 16'h5800 : {8'h0, d};
      if (brk) m_s2 = m_s2 | 16'h0004;
    end
  endtask

  task automatic irq_chk(string req_tag);
    @(negedge clk);
    chk(req_tag, {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  task automatic read_all(string req_tag);
    int idxs[13] = '{'h00, 'h20, 'h21, 'h22, 'h23, 'h24, 'h25, 'h26, 'h29, 'h2A, 'h2B, 'h2C, 'h2D};
    foreach (idxs[i]) if (idxs[i] != 0) bus_rd(idxs[i], req_tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    read_all("R1 reset value");
    bus_rd('h00, "R1/R8 empty rxd");
    bus_rd('h10, "R2 txd reads zero");
    bus_rd('h3F, "R2 undefined read");
    // R2 undefined writes have no effect, R10 test write ignored
    bus_wr('h3F, 32'hFFFF_FFFF); bus_wr('h2D, 32'hFFFF); bus_wr('h2B, 32'h1234);
    read_all("R2/R10 no effect");
    // R3 masked writes
    bus_wr('h22, 32'hABCD_1357); bus_rd('h22, "R3 ctl3 low16");
    bus_wr('h29, 32'h5555_0077); bus_rd('h2B, "R3 inc lands in count");
    bus_rd('h29, "R3 inc reads zero");
    // R13 timing, R11
    bus_wr('h20, 32'h2000);
    chk("R13 irq not yet", {31'h0, irq}, 32'h0);
    irq_chk("R11/R13 trdy irq");
    bus_wr('h20, 32'h0); irq_chk("R13 irq drops");
    // R12
    bus_wr('h23, 32'h8); irq_chk("R12 txdc irq");
    bus_wr('h23, 32'h1); irq_chk("R12 rdr disabled empty");
    rx_push(8'hA5, 0); irq_chk("R12 rdr irq");
    bus_rd('h2D, "R5 test rx-empty clear");
    bus_rd('h25, "R5 sts1 rrdy");
    rx_push(8'h3C, 0); rx_push(8'h00, 1);
    bus_rd('h26, "R6 no break when full");
    bus_rd('h00, "R8 rxd with char-ready");
    bus_rd('h00, "R8 empty read no change");
    irq_chk("R12 irq drops after read");
    bus_wr('h23, 32'h0);
    // R7 break
    rx_push(8'h00, 1); bus_rd('h26, "R7 break detect"); bus_rd('h00, "R7 break word");
    bus_wr('h26, 32'hFFFF); bus_rd('h26, "R10 sts2 w1c");
    bus_wr('h25, 32'hFFFF); bus_rd('h25, "R10 sts1 w1c");
    bus_wr('h20, 32'h0040); irq_chk("R12 txfe irq");
    // R9
    bus_wr('h10, 32'h11); bus_wr('h21, 32'h0005); bus_wr('h10, 32'h1C3);
    bus_rd('h25, "R9 trdy kept"); bus_rd('h26, "R9 txdc kept");
    // R4 software reset with full buffer
    rx_push(8'h77, 0); bus_wr('h2C, 32'h99);
    bus_wr('h21, 32'h0006);
    read_all("R4 after srst"); bus_rd('h00, "R4 rxd after srst");
    irq_chk("R4 irq after srst");

    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: begin
          int regs[7] = '{'h20, 'h22, 'h23, 'h24, 'h29, 'h2A, 'h2C};
          bus_wr(regs[$urandom_range(0, 6)], $urandom());
        end
        1: bus_wr('h21, $urandom() | 32'h1);
        2: begin
          int regs[14] = '{'h00, 'h10, 'h20, 'h21, 'h22, 'h23, 'h24, 'h25, 'h26, 'h29, 'h2A, 'h2B, 'h2C, 'h2D};
          bus_rd(regs[$urandom_range(0, 13)], "R2/R3 random read");
        end
        3: rx_push(8'($urandom()), 0);
        4: rx_push(8'($urandom()), ($urandom_range(0, 2) == 0));
        5: bus_rd('h00, "R8 random rxd");
        6: bus_wr('h10, $urandom());
        7: bus_wr($urandom_range(0, 1) ? 'h25 : 'h26, $urandom());
        8: bus_wr($urandom_range(0, 1) ? 'h2D : 'h30 + $urandom_range(0, 8), $urandom());
        default: if ($urandom_range(0, 7) == 0) bus_wr('h21, $urandom() & 32'hFFFF_FFFE);
                 else bus_rd('h26, "R5/R7 random sts2");
      endcase
      irq_chk("R11/R12 random irq");
    end
    read_all("R3 final readback");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule